// File: doc/BRIEF.md
# Parked-Port Test Clock Cycle Counter

This block forwards the test clock to one local scan port and can stop it after an exact number of cycles. It lets a self-test sequence on a parked port run for a known count of clocks while the rest of the scan network is busy. A count word is shifted in serially while the counter-select instruction is active, and the Update-DR strobe then copies it into a down-counter. The counter-on instruction level and the port-parked level together arm the gating. In that state every forwarded rising edge takes one off the count, and at zero the port clock is held low.

A sticky terminal-count flag reports the stop. A status register would present it as bit 7 of its mode word. The flag is cleared only by the next load. The enable for the gate is captured on the falling test clock edge. A forwarded high phase is therefore never shortened, and a spurious edge never appears.

Top module: `tcc_parked_counter`

## Requirements
- R1: While `trst_n` is low, and in the first cycle after it is released, `tc_flag` and `scan_out` are 0 and the count register is 0.
- R2: On each rising `tck` edge with `cnt_select` and `dr_shift` both high, the shift stage moves one place toward bit 0 and takes `scan_in` into its top bit. `scan_out` is bit 0, so a word shifted least significant bit first reads its bit 0 on `scan_out` after 32 shifts.
- R3: Shift and update strobes have no effect while `cnt_select` is low. Shifting with `cnt_select` high does not change an ongoing count.
- R4: A rising edge with `cnt_select` and `dr_update` both high copies the shift stage into the count register and clears `tc_flag` in the same edge.
- R5: With `count_enable` and `port_parked` high, after a load of N exactly N pulses reach `port_tck`. After that `port_tck` stays low, and the count never goes below zero.
- R6: While `count_enable` or `port_parked` is low, `port_tck` follows `tck` and the count holds its value.
- R7: `tc_flag` becomes 1 only after a cycle in which the count is zero and `count_enable` is high. It then stays 1 until the next load.
- R8: A load of zero with the counter armed forwards no pulse at all.
- R9: The gate enable changes only while `tck` is low, so `port_tck` is low whenever `tck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| scan_in | input | 1 | Serial count data |
| cnt_select | input | 1 | Counter-select instruction decoded |
| dr_shift | input | 1 | Shift-DR state strobe |
| dr_update | input | 1 | Update-DR state strobe |
| count_enable | input | 1 | Counter-on instruction decoded |
| port_parked | input | 1 | Local port is parked |
| scan_out | output | 1 | Serial output of the shift stage |
| port_tck | output | 1 | Gated clock to the local port |
| tc_flag | output | 1 | Sticky terminal-count status |

## Verification
The counter is tried with a load of zero, a short load of five, and a long load of forty that keeps counting while a new word is shifted in. Together these separate an off-by-one in the stop point from a shift path that disturbs the count. Free-running windows with the port unparked or the counter off show whether counting or gating leaks outside the armed state. Shift and update strobes given with the select low show whether the instruction qualification is present. A second load given after a stop shows whether the flag is truly sticky and whether the load clears it.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   // Action taken by the count register on a rising test clock edge
   typedef enum logic [1:0] {
      TCC_HOLD = 2'd0,
      TCC_LOAD = 2'd1,
      TCC_DEC  = 2'd2
   } tcc_act_e;
endpackage

// File: rtl/tcc_shift_stage.sv
module tcc_shift_stage #(
   parameter int CNT_W     = 32,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             shift_en,
   input  logic             sin,
   output logic [CNT_W-1:0] word,
   output logic             sout
);
   logic [CNT_W-1:0] sh_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)       sh_q <= '0;
            else if (shift_en) sh_q <= {sin, sh_q[CNT_W-1:1]};
         end
         assign sout = sh_q[0];
      end else begin : g_msb
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)       sh_q <= '0;
            else if (shift_en) sh_q <= {sh_q[CNT_W-2:0], sin};
         end
         assign sout = sh_q[CNT_W-1];
      end
   endgenerate

   assign word = sh_q;
endmodule

// File: rtl/tcc_down_counter.sv
module tcc_down_counter
   import tcc_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             armed,
   input  logic             gate_open,
   input  logic             stat_en,
   output logic [CNT_W-1:0] count,
   output logic             is_zero,
   output logic             flag
);
   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   tcc_act_e         act;

   assign is_zero = (cnt_q == '0);

   always_comb begin
      if (load)                               act = TCC_LOAD;
      else if (armed && gate_open && !is_zero) act = TCC_DEC;
      else                                     act = TCC_HOLD;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (act)
            TCC_LOAD: cnt_q <= load_val;
            TCC_DEC:  cnt_q <= cnt_q - 1'b1;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                  flag_q <= 1'b0;
      else if (act == TCC_LOAD)     flag_q <= 1'b0;
      else if (stat_en && is_zero)  flag_q <= 1'b1;
   end

   assign count = cnt_q;
   assign flag  = flag_q;
endmodule

// File: rtl/tcc_clk_gate.sv
module tcc_clk_gate (
   input  logic tck,
   input  logic trst_n,
   input  logic stop_req,
   output logic gate_open,
   output logic gclk
);
   logic en_q;

   // Enable is sampled on the falling edge: changes land in the low phase
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) en_q <= 1'b1;
      else         en_q <= !stop_req;
   end

   assign gate_open = en_q;
   assign gclk      = tck & en_q;
endmodule

// File: rtl/tcc_parked_counter.sv
module tcc_parked_counter #(
   parameter int CNT_W     = 32,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic scan_in,
   input  logic cnt_select,
   input  logic dr_shift,
   input  logic dr_update,
   input  logic count_enable,
   input  logic port_parked,
   output logic scan_out,
   output logic port_tck,
   output logic tc_flag
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tcc_parked_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] sh_word;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_zero;
   logic             gate_open;
   logic             armed;
   logic             do_load;

   assign armed   = count_enable & port_parked;
   assign do_load = cnt_select & dr_update;

   tcc_shift_stage #(
      .CNT_W     (CNT_W),
      .LSB_FIRST (LSB_FIRST)
   ) shift_i (
      .tck      (tck),
      .trst_n   (trst_n),
      .shift_en (cnt_select & dr_shift),
      .sin      (scan_in),
      .word     (sh_word),
      .sout     (scan_out)
   );

   tcc_down_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .tck       (tck),
      .trst_n    (trst_n),
      .load      (do_load),
      .load_val  (sh_word),
      .armed     (armed),
      .gate_open (gate_open),
      .stat_en   (count_enable),
      .count     (cnt_q),
      .is_zero   (cnt_zero),
      .flag      (tc_flag)
   );

   tcc_clk_gate gate_i (
      .tck       (tck),
      .trst_n    (trst_n),
      .stop_req  (armed & cnt_zero),
      .gate_open (gate_open),
      .gclk      (port_tck)
   );
endmodule

// File: rtl/tcc_parked_counter_chk.sv
module tcc_parked_counter_chk #(
   parameter int CNT_W = 32
) (
   input logic             tck,
   input logic             trst_n,
   input logic             cnt_select,
   input logic             dr_update,
   input logic             count_enable,
   input logic             port_parked,
   input logic             port_tck,
   input logic             tc_flag,
   input logic [CNT_W-1:0] count
);
   logic ld;
   assign ld = cnt_select & dr_update;

   AST_LOAD_CLEARS_FLAG: assert property (@(posedge tck) disable iff (!trst_n)
      ld |=> !tc_flag); // R4
   AST_FLAG_STICKY: assert property (@(posedge tck) disable iff (!trst_n)
      (tc_flag && !ld) |=> tc_flag); // R7
   AST_FLAG_NEEDS_ENABLE: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(tc_flag) |-> $past(count_enable)); // R7
   AST_NO_WRAP: assert property (@(posedge tck) disable iff (!trst_n)
      (count == '0 && !ld) |=> (count == '0)); // R5
   AST_STEP_ONE: assert property (@(posedge tck) disable iff (!trst_n)
      (count != '0 && !ld) |=> (count == $past(count) || count == $past(count) - 1'b1)); // R5
   AST_HOLD_UNARMED: assert property (@(posedge tck) disable iff (!trst_n)
      (!(count_enable && port_parked) && !ld) |=> $stable(count)); // R6
   AST_LOW_PHASE_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
      !port_tck); // R9
endmodule

bind tcc_parked_counter tcc_parked_counter_chk #(.CNT_W(CNT_W)) chk_i (
   .tck          (tck),
   .trst_n       (trst_n),
   .cnt_select   (cnt_select),
   .dr_update    (dr_update),
   .count_enable (count_enable),
   .port_parked  (port_parked),
   .port_tck     (port_tck),
   .tc_flag      (tc_flag),
   .count        (cnt_q)
);

// File: tb/tcc_parked_counter_tb_top.sv
`timescale 1ns/1ps
module tcc_parked_counter_tb_top;
   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic scan_in = 1'b0, cnt_select = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
   logic count_enable = 1'b0, port_parked = 1'b0;
   logic scan_out, port_tck, tc_flag;

   int n_vec = 0;
   int n_bad = 0;
   int pulses = 0;
   bit done = 1'b0;

   typedef struct {
      string req;
      int    exp;
   } exp_item_t;
   exp_item_t sb_q[$];

   always #4 tck = ~tck;   // 125 MHz

   tcc_parked_counter dut_i (
      .tck(tck), .trst_n(trst_n), .scan_in(scan_in), .cnt_select(cnt_select),
      .dr_shift(dr_shift), .dr_update(dr_update), .count_enable(count_enable),
      .port_parked(port_parked), .scan_out(scan_out), .port_tck(port_tck),
      .tc_flag(tc_flag)
   );

   always @(posedge port_tck) pulses++;

   task automatic tick();
      @(negedge tck);
      #1;
   endtask

   // driver side: record an expected result
   task automatic expect_val(string req, int exp);
      exp_item_t it;
      it.req = req;
      it.exp = exp;
      sb_q.push_back(it);
   endtask

   // monitor side: pop the oldest expectation and compare with an observation
   task automatic observe(int act);
      exp_item_t it;
      n_vec++;
      if (sb_q.size() == 0) begin
         n_bad++;
         $display("FAIL scoreboard empty: actual %0d expected none", act);
      end else begin
         it = sb_q.pop_front();
         if (act != it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", it.req, act, it.exp);
         end
      end
   endtask

   task automatic shift_word(logic [31:0] v);
      cnt_select = 1'b1;
      for (int i = 0; i < 32; i++) begin
         scan_in  = v[i];
         dr_shift = 1'b1;
         tick();
      end
      dr_shift = 1'b0;
   endtask

   task automatic update();
      dr_update = 1'b1;
      tick();
      dr_update = 1'b0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      run(3);
      expect_val("R1 flag in reset", 0);     observe(int'(tc_flag));
      expect_val("R1 scan_out in reset", 0); observe(int'(scan_out));
      trst_n = 1'b1;
      tick();
      expect_val("R1 flag after reset", 0);  observe(int'(tc_flag));

      // R8: armed with count zero from reset -> no pulses, flag sets (R7)
      count_enable = 1'b1; port_parked = 1'b1;
      tick();
      pulses = 0;
      run(10);
      expect_val("R8 pulses at zero count", 0); observe(pulses);
      expect_val("R7 flag at zero", 1);         observe(int'(tc_flag));

      // R2/R4/R5: load five
      shift_word(32'd5);
      expect_val("R2 scan_out bit0 of word", 1); observe(int'(scan_out));
      pulses = 0;
      update();
      expect_val("R4 load clears flag", 0); observe(int'(tc_flag));
      run(20);
      expect_val("R5 five pulses", 5);  observe(pulses);
      expect_val("R7 flag at stop", 1); observe(int'(tc_flag));

      count_enable = 1'b0; port_parked = 1'b0;
      run(4);
      expect_val("R7 flag sticky", 1); observe(int'(tc_flag));

      // R3: strobes without select are ignored
      cnt_select = 1'b0;
      scan_in = 1'b0; dr_shift = 1'b1;
      run(8);
      dr_shift = 1'b0;
      expect_val("R3 shift ignored", 1); observe(int'(scan_out));
      dr_update = 1'b1; tick(); dr_update = 1'b0;
      expect_val("R3 update ignored flag", 1); observe(int'(tc_flag));
      count_enable = 1'b1; port_parked = 1'b1;
      tick();
      pulses = 0;
      run(10);
      expect_val("R3 count still zero", 0); observe(pulses);

      // R6: load forty, counter off -> free running, count held
      count_enable = 1'b0;
      tick();
      shift_word(32'd40);
      update();
      expect_val("R4 flag cleared by load", 0); observe(int'(tc_flag));
      pulses = 0;
      run(10);
      expect_val("R6 free with counter off", 10); observe(pulses);

      // R5/R3: arm, shift a new word meanwhile, exactly forty pulses
      count_enable = 1'b1;
      pulses = 0;
      shift_word(32'd3);
      run(28);
      expect_val("R5 forty pulses with shift", 40); observe(pulses);
      expect_val("R2 new word bit0", 1);            observe(int'(scan_out));
      pulses = 0;
      update();
      run(10);
      expect_val("R4 reload three pulses", 3); observe(pulses);

      // R6: unparked port runs free even at zero
      port_parked = 1'b0;
      tick();
      pulses = 0;
      run(10);
      expect_val("R6 free when unparked", 10); observe(pulses);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule